// File: doc/BRIEF.md
# GPIO Controller with Interrupt Detection

This block gives a processor sixteen general-purpose pins behind a small 32-bit register bus. Software sets the value each pin drives and whether its driver is enabled, and it reads back the pin levels after a two-flop synchronizer. Each pin also has its own trigger detector. The detector can fire on a high level, a low level, a rising edge, a falling edge or any change. Fired events are held in a sticky status register until software writes ones to clear them.

The low thirteen lines each have a dedicated active-high interrupt wire that follows the line's sticky status bit. The upper three lines still latch status, but only polling can see it. Each pin's three-bit trigger code lives in one of two packed configuration words, eight codes per word. The bus decodes byte offsets: 0x00 output value, 0x04 direction, 0x08 pin levels (read only), 0x0C status, 0x10 codes for lines 0 to 7 and 0x14 codes for lines 8 to 15. Offsets 0x18 and 0x1C are reserved slots.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the output-value, status and trigger-code registers read zero and the direction register reads 0xFFFF, so every pin starts with its driver off.
- R2: pad_out mirrors the output-value register. pad_oe[n] is high exactly when direction bit n is 0, since a 1 in the direction register makes the line an input.
- R3: Offset 0x08 returns each pin's level after two clock stages of synchronization, so a pin change shows up in a read issued two cycles later and not in a read issued one cycle after it.
- R4: Trigger code 0 (level high) and code 1 (level low) set the line's status on every cycle the level holds, so a clear while the level persists leaves the bit set.
- R5: Code 2 sets status only on a 0-to-1 change of the synchronized pin, and code 3 only on a 1-to-0 change. A steady level never sets it.
- R6: Code 4 sets status on either direction of change.
- R7: Codes 5, 6 and 7 never set status.
- R8: Line n takes its code from bits [3(n mod 8)+2 : 3(n mod 8)] of offset 0x10 when n < 8, and of offset 0x14 when n >= 8. Bits 31:24 of both words read zero.
- R9: A write to offset 0x0C clears each status bit written as 1 and leaves the bits written as 0 unchanged.
- R10: When a clearing write and a new event reach the same status bit in the same cycle, the bit stays set.
- R11: irq_out[n] equals status bit n for lines 0 to 12, and no other line affects irq_out.
- R12: Offsets 0x18 and 0x1C, and unused upper bits of every register, read zero. Writes to those places and to offset 0x08 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data appears on bus_rdata after the next edge |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 16 | Pin levels from the pads, asynchronous |
| pad_out | output | 16 | Value to drive on each pin |
| pad_oe | output | 16 | Output enable for each pin |
| irq_out | output | 13 | Per-line active-high interrupts for lines 0 to 12 |

## Verification
The bench sweeps all eight trigger codes over all sixteen lines. Each code is configured through the packed field that belongs to that line, so a shifted field position makes a different line respond or none at all. In that sweep, a level code that let a clear win would read back zero while its level still held. An edge code that fired on a steady level would show status after a clear when it should not. A reserved code that leaked into a valid mode would latch events. One case places a clearing write in exactly the cycle a new transition is detected, and a design that let the clear win would lose that event. Partial clears, the input synchronizer latency and the reserved offsets are also checked. A design that cleared by writing zeros, sampled the pins one stage early, or kept bits in the reserved slots would fail those checks.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
  localparam int DATA_W          = 32;
  localparam int STYLE_W         = 3;
  localparam int FIELDS_PER_WORD = 8;
  localparam int TYPE_W          = STYLE_W * FIELDS_PER_WORD;

  // word indices on the bus (byte offset / 4)
  localparam int WRD_OUT   = 0;
  localparam int WRD_DIR   = 1;
  localparam int WRD_PIN   = 2;
  localparam int WRD_STAT  = 3;
  localparam int WRD_TYPE0 = 4;

  typedef enum logic [STYLE_W-1:0] {
    TRIG_HIGH = 3'd0,
    TRIG_LOW  = 3'd1,
    TRIG_RISE = 3'd2,
    TRIG_FALL = 3'd3,
    TRIG_ANY  = 3'd4
  } trig_e;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  // no reset on synchronizer flops
  always_ff @(posedge clk) begin
    meta_q <= d_i;
    sync_q <= meta_q;
  end

  assign q_o = sync_q;

  // R3
  sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
    q_o == $past(d_i, 2));
endmodule

// File: rtl/gpio_trig.sv
`timescale 1ns/1ps
module gpio_trig
  import gpio_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [STYLE_W-1:0] style_i,
  input  logic               cur_i,
  input  logic               prev_i,
  output logic               hit_o
);
  always_comb begin
    case (style_i)
      TRIG_HIGH: hit_o = cur_i;
      TRIG_LOW:  hit_o = !cur_i;
      TRIG_RISE: hit_o = cur_i && !prev_i;
      TRIG_FALL: hit_o = !cur_i && prev_i;
      TRIG_ANY:  hit_o = cur_i ^ prev_i;
      default:   hit_o = 1'b0;
    endcase
  end

  // R7
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (style_i > STYLE_W'(TRIG_ANY)) |-> !hit_o);

  // R5
  rise_only_chk: assert property (@(posedge clk) disable iff (rst)
    (style_i == TRIG_RISE && hit_o) |-> (cur_i && !prev_i));

  // R5
  fall_only_chk: assert property (@(posedge clk) disable iff (rst)
    (style_i == TRIG_FALL && hit_o) |-> (!cur_i && prev_i));
endmodule

// File: rtl/gpio_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_irq_ctrl
  import gpio_pkg::*;
#(
  parameter int LINES     = 16,
  parameter int IRQ_LINES = 13,
  parameter int ADDR_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [LINES-1:0]     pad_in,
  output logic [LINES-1:0]     pad_out,
  output logic [LINES-1:0]     pad_oe,
  output logic [IRQ_LINES-1:0] irq_out
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int NTYPE  = (LINES + FIELDS_PER_WORD - 1) / FIELDS_PER_WORD;

  logic [WORD_W-1:0]           word;
  logic [LINES-1:0]            out_q, dir_q, st_q;
  logic [LINES-1:0]            sync_q, prev_q, hit, w1c_mask;
  logic [NTYPE-1:0][TYPE_W-1:0] typ_q;
  logic [DATA_W-1:0]           rd_mux;
  logic                        unused_bits;

  assign word        = bus_addr[ADDR_W-1:2];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:TYPE_W]};

  gpio_sync #(.W(LINES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pad_in),
    .q_o (sync_q)
  );

  always_ff @(posedge clk) prev_q <= sync_q;

  for (genvar n = 0; n < LINES; n++) begin : g_line
    localparam int R = n / FIELDS_PER_WORD;
    localparam int F = n % FIELDS_PER_WORD;
    gpio_trig u_trig (
      .clk     (clk),
      .rst     (rst),
      .style_i (typ_q[R][STYLE_W*F +: STYLE_W]),
      .cur_i   (sync_q[n]),
      .prev_i  (prev_q[n]),
      .hit_o   (hit[n])
    );
  end

  assign w1c_mask = (bus_wr && word == WORD_W'(WRD_STAT)) ? bus_wdata[LINES-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      dir_q <= '1;
      st_q  <= '0;
      typ_q <= '0;
    end else begin
      if (bus_wr && word == WORD_W'(WRD_OUT)) out_q <= bus_wdata[LINES-1:0];
      if (bus_wr && word == WORD_W'(WRD_DIR)) dir_q <= bus_wdata[LINES-1:0];
      for (int k = 0; k < NTYPE; k++)
        if (bus_wr && word == WORD_W'(WRD_TYPE0 + k)) typ_q[k] <= bus_wdata[TYPE_W-1:0];
      // new events win over a clear in the same cycle
      st_q <= (st_q & ~w1c_mask) | hit;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (word)
      WORD_W'(WRD_OUT):  rd_mux[LINES-1:0] = out_q;
      WORD_W'(WRD_DIR):  rd_mux[LINES-1:0] = dir_q;
      WORD_W'(WRD_PIN):  rd_mux[LINES-1:0] = sync_q;
      WORD_W'(WRD_STAT): rd_mux[LINES-1:0] = st_q;
      default: ;
    endcase
    for (int k = 0; k < NTYPE; k++)
      if (word == WORD_W'(WRD_TYPE0 + k)) rd_mux[TYPE_W-1:0] = typ_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign pad_out = out_q;
  assign pad_oe  = ~dir_q;
  assign irq_out = st_q[IRQ_LINES-1:0];

  // R9
  clear_by_write_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(st_q) & ~st_q & ~$past(w1c_mask)) == '0));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (dir_q == '1 && out_q == '0 && typ_q == '0));
endmodule

// File: tb/gpio_irq_ctrl_test.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pad = '0;
  logic [15:0] pad_out, pad_oe;
  logic [12:0] irq_out;
  int total = 0, bad = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  gpio_irq_ctrl uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic string style_tag(input int s);
    case (s)
      0, 1: return "R4 level";
      2, 3: return "R5 edge";
      4:    return "R6 any";
      default: return "R7 reserved";
    endcase
  endfunction

  task automatic status_chk(input int n, input int s, input bit e);
    logic [31:0] v;
    logic [12:0] irq_exp;
    string t;
    t = $sformatf("%s R8 line=%0d code=%0d", style_tag(s), n, s);
    rd(5'h0C, v);
    chk(t, v, e ? (32'h1 << n) : 32'h0);
    irq_exp = (e && n < 13) ? (13'h1 << n) : 13'h0;
    chk($sformatf("R11 irq line=%0d code=%0d", n, s), {19'h0, irq_out}, {19'h0, irq_exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit e;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(5'h00, rv); chk("R1 out", rv, 32'h0);
    rd(5'h04, rv); chk("R1 dir", rv, 32'h0000_FFFF);
    rd(5'h0C, rv); chk("R1 status", rv, 32'h0);
    rd(5'h10, rv); chk("R1 type lo", rv, 32'h0);
    rd(5'h14, rv); chk("R1 type hi", rv, 32'h0);
    chk("R1 oe", {16'h0, pad_oe}, 32'h0);

    // R2 output and direction
    wr(5'h00, 32'hFFFF_A5C3);
    wr(5'h04, 32'h1234_0F0F);
    chk("R2 pad_out", {16'h0, pad_out}, 32'h0000_A5C3);
    chk("R2 pad_oe", {16'h0, pad_oe}, 32'h0000_F0F0);
    rd(5'h00, rv); chk("R2 out rb", rv, 32'h0000_A5C3);
    rd(5'h04, rv); chk("R12 dir upper", rv, 32'h0000_0F0F);

    // R12 reserved offsets and read-only pins
    wr(5'h18, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    rd(5'h18, rv); chk("R12 slot18", rv, 32'h0);
    rd(5'h1C, rv); chk("R12 slot1C", rv, 32'h0);
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, rv); chk("R12 pin write ignored", rv, 32'h0);
    wr(5'h10, 32'hFF00_0000);
    rd(5'h10, rv); chk("R8 type upper bits", rv, 32'h0);
    rd(5'h0C, rv); chk("R12 no stray status", rv, 32'h0);

    // R3 synchronizer latency (codes still 0 and rise would stay level: use code 5)
    wr(5'h10, 32'h00B6_DB6D & 32'h00FF_FFFF);
    wr(5'h14, 32'h00B6_DB6D & 32'h00FF_FFFF);
    wr(5'h10, 32'h00B6_DB6D);
    @(negedge clk);
    pad = 16'h5AF0;
    bus_rd = 1'b1; bus_addr = 5'h08;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R3 not after one cycle", bus_rdata, 32'h0);
    idle(1);
    rd(5'h08, rv); chk("R3 pins", rv, 32'h0000_5AF0);
    pad = 16'h0000;
    idle(4);

    // R9 partial clear with rising codes on all lines
    wr(5'h10, 32'h0049_2492);
    wr(5'h14, 32'h0049_2492);
    wr(5'h0C, 32'hFFFF);
    pad = 16'hFFFF; idle(4);
    pad = 16'h0000; idle(4);
    rd(5'h0C, rv); chk("R5 all rise", rv, 32'h0000_FFFF);
    wr(5'h0C, 32'h0000_00F0);
    rd(5'h0C, rv); chk("R9 partial clear", rv, 32'h0000_FF0F);
    wr(5'h0C, 32'h0000_0000);
    rd(5'h0C, rv); chk("R9 zero write", rv, 32'h0000_FF0F);
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h0C, rv); chk("R9 full clear", rv, 32'h0);

    // R10 clear and event in the same cycle: any-change on line 0
    wr(5'h10, 32'h0000_0004);
    wr(5'h14, 32'h0);
    idle(2);
    pad = 16'h0001;          // at a negedge: E1 meta, E2 sync, E3 status
    @(negedge clk);
    wr(5'h0C, 32'h1);        // strobe sampled at E3
    rd(5'h0C, rv); chk("R10 event wins", rv, 32'h1);
    wr(5'h0C, 32'h1);
    rd(5'h0C, rv); chk("R9 clear after", rv, 32'h0);
    pad = 16'h0000; idle(4);
    wr(5'h10, 32'h0);
    wr(5'h0C, 32'hFFFF);

    // R4..R8, R11 sweep over all lines and codes
    for (int n = 0; n < 16; n++) begin
      for (int s = 0; s < 8; s++) begin
        bit e1, e2, e3, e4, e5;
        logic [31:0] tv;
        tv = 32'(s) << (3 * (n % 8));
        wr(5'h10, (n < 8) ? tv : 32'h0);
        wr(5'h14, (n < 8) ? 32'h0 : tv);
        idle(3);
        wr(5'h0C, 32'hFFFF);
        e1 = (s == 1);
        status_chk(n, s, e1);
        pad[n] = 1'b1; idle(4);
        e2 = e1 | (s == 0) | (s == 2) | (s == 4);
        status_chk(n, s, e2);
        wr(5'h0C, 32'hFFFF);
        e3 = (s == 0);
        status_chk(n, s, e3);
        pad[n] = 1'b0; idle(4);
        e4 = e3 | (s == 1) | (s == 3) | (s == 4);
        status_chk(n, s, e4);
        wr(5'h0C, 32'hFFFF);
        e5 = (s == 1);
        status_chk(n, s, e5);
        wr(5'h10, 32'h0);
        wr(5'h14, 32'h0);
        wr(5'h0C, 32'hFFFF);
      end
    end
    e = 1'b0;
    rd(5'h0C, rv); chk("R4 final quiet", rv, {31'h0, e});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule